// File: doc/BRIEF.md
# Timer-Triggered Transmit Task Sequencer

This block sequences transmit tasks for a byte-serial packet transmitter. Software issues strobe commands (start transmit, reset FIFO), fills a transmit FIFO, and sets a packet length. A free-running periodic timer produces a one-clock event on every wrap. A small router either passes that event toward the task engine or blocks it. When the task is configured to start on a timer event, a transmit command parks in a waiting state until an event is available.

Timer events are captured in a sticky latch. A captured event stays pending until a task start uses it or until the engine is disabled. A stale event therefore lets the next transmit start at once, without waiting for the next period. A transmit command issued while a task is active aborts that task, reports an abort end cause, and starts the new task. When the FIFO runs dry during a packet, the transmitter sends zero bytes until software resets the FIFO. The packet still completes, and a sticky underflow flag is raised.

Top module: `tx_task_seq`

## Requirements
- R1: While `timerRun` is high, `timerEvt` pulses for exactly one clock, once every `timerPeriod` clocks. The pulse follows the counter wrapping from `timerPeriod`-1 to 0. Periods of 2 or more are supported.
- R2: Holding `engEnable` low does not disturb the timer: the spacing between events stays `timerPeriod` across an engine reset.
- R3: The transmit command is `cmdCode` 2'b01. With `startOnEvt` low, `engState` reads 2 (sending) two clocks after the command is strobed.
- R4: With `startOnEvt` high and no event pending, a transmit command holds `engState` at 1 (waiting). A routed event makes it 2 (sending) two clocks after the pulse.
- R5: A routed event that arrives while no task waits is latched. The next transmit with `startOnEvt` high reaches sending on the second clock after the command, without waiting for a new event. `engState` reads 0 only when no task runs and no transmit start is pending.
- R6: Driving `engEnable` low makes `engState` read 3, clears the pending event, the task and the FIFO. A transmit issued afterwards waits for a fresh event.
- R7: `evtRoute` value 3'd7 blocks timer events: events seen while blocked are not latched. Any other value passes them.
- R8: A transmit command while a task is waiting or sending aborts it. `endCause` becomes 6 and `taskDone` is set on the clock the new task starts.
- R9: A task sends `pktLen` bytes (1 or more) in FIFO write order, one byte every BYTE_CYCLES clocks on `txValid`/`txData`. On the last byte, `endCause` becomes 1, `taskDone` is set and `engState` returns to 0.
- R10: Needing a byte while the FIFO is empty sets `underflowErr`. Every later byte is zero, even if the FIFO is refilled, until a FIFO reset (`cmdCode` 2'b10). Bytes written during this zero mode stay unread.
- R11: A `statusClr` pulse clears `taskDone` and `underflowErr`.
- R12: `cmdBusy` is high on the clock after a strobe. `fifoLevel` counts stored bytes. Writes to a full FIFO are dropped. A FIFO reset empties it.
- R13: After reset, `engState`, `endCause`, `fifoLevel`, `taskDone`, `underflowErr`, `txValid` and `cmdBusy` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| engEnable | input | 1 | Engine enable; low holds the task engine in reset |
| timerRun | input | 1 | Timer count enable |
| timerPeriod | input | PERIOD_W | Timer period in clocks (2 or more) |
| evtRoute | input | 3 | Event route; 7 blocks timer events |
| startOnEvt | input | 1 | Transmit waits for a timer event |
| pktLen | input | LEN_W | Bytes per packet |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 2 | 01 transmit, 10 FIFO reset |
| cmdBusy | output | 1 | Command being processed |
| fifoWrEn | input | 1 | FIFO write enable |
| fifoWrData | input | DATA_W | FIFO write data |
| fifoLevel | output | clog2(FIFO_DEPTH+1) | Bytes in FIFO |
| statusClr | input | 1 | Clear task-done and underflow flags |
| txValid | output | 1 | Output byte valid |
| txData | output | DATA_W | Output byte |
| engState | output | 2 | 0 idle, 1 waiting, 2 sending, 3 in reset |
| endCause | output | 3 | 0 none, 1 success, 6 aborted |
| taskDone | output | 1 | Sticky task-ended flag |
| underflowErr | output | 1 | Sticky FIFO underflow flag |
| timerEvt | output | 1 | Timer wrap event pulse |

## Verification
The bench builds the block with FIFO_DEPTH 8 and BYTE_CYCLES 4, and drives a timer period of 40 clocks. A full FIFO, overflowing writes and whole packets are then only a few dozen clocks long. Many timer periods fit in one run, so stale, blocked, fresh and reset-cleared events can each be placed precisely between wraps. Abort timing is checked mid-packet, and zero mode is checked to persist across a refill and end at a FIFO reset.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_SEND = 2'd2} state_e;

  typedef struct packed {
    logic fifoFlush;
    logic byteSlot;
  } dpCtl_t;

  localparam logic [1:0] CMD_TX    = 2'b01;
  localparam logic [1:0] CMD_FLUSH = 2'b10;

  localparam logic [2:0] END_NONE  = 3'd0;
  localparam logic [2:0] END_OK    = 3'd1;
  localparam logic [2:0] END_ABORT = 3'd6;

  localparam logic [2:0] ROUTE_OFF = 3'd7;

  localparam logic [1:0] ENG_IDLE  = 2'd0;
  localparam logic [1:0] ENG_WAIT  = 2'd1;
  localparam logic [1:0] ENG_SEND  = 2'd2;
  localparam logic [1:0] ENG_RESET = 2'd3;
endpackage

// File: rtl/tx_seq_datapath.sv
module tx_seq_datapath
  import tx_seq_pkg::*;
#(
  parameter int PERIOD_W   = 16,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                engEnable,
  input  logic                timerRun,
  input  logic [PERIOD_W-1:0] timerPeriod,
  output logic                timerEvt,
  input  logic                fifoWrEn,
  input  logic [DATA_W-1:0]   fifoWrData,
  output logic [LEVEL_W-1:0]  fifoLevel,
  input  dpCtl_t              ctl,
  input  logic                statusClr,
  output logic                txValid,
  output logic [DATA_W-1:0]   txData,
  output logic                underflowErr
);
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(FIFO_DEPTH - 1);
  localparam logic [LEVEL_W-1:0] LEVEL_FULL = LEVEL_W'(FIFO_DEPTH);

  // periodic timer
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] lastCnt;
  logic                wrapNow;

  assign lastCnt = timerPeriod - PERIOD_W'(1);
  assign wrapNow = timerRun && (cnt >= lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      timerEvt <= 1'b0;
    end else begin
      timerEvt <= wrapNow;
      if (timerRun) cnt <= (cnt >= lastCnt) ? '0 : cnt + PERIOD_W'(1);
    end
  end

  // transmit FIFO
  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0]     rdPtr, wrPtr;
  logic              fifoClear, fifoEmpty, doPush, doPop, zeroMode, useZero;

  assign fifoClear = !engEnable || ctl.fifoFlush;
  assign fifoEmpty = (fifoLevel == '0);
  assign useZero   = zeroMode || fifoEmpty;
  assign doPush    = fifoWrEn && !fifoClear && (fifoLevel != LEVEL_FULL);
  assign doPop     = ctl.byteSlot && !useZero && !fifoClear;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= fifoWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || fifoClear) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      fifoLevel <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + AW'(1);
      case ({doPush, doPop})
        2'b10:   fifoLevel <= fifoLevel + LEVEL_W'(1);
        2'b01:   fifoLevel <= fifoLevel - LEVEL_W'(1);
        default: fifoLevel <= fifoLevel;
      endcase
    end
  end

  // byte output and zero-fill mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid      <= 1'b0;
      txData       <= '0;
      zeroMode     <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      txValid <= ctl.byteSlot;
      if (ctl.byteSlot) txData <= useZero ? '0 : mem[rdPtr];
      if (fifoClear) zeroMode <= 1'b0;
      else if (ctl.byteSlot && useZero) zeroMode <= 1'b1;
      if (ctl.byteSlot && useZero) underflowErr <= 1'b1;
      else if (statusClr) underflowErr <= 1'b0;
    end
  end

  a_r1_evt_one_wide: assert property (@(posedge clk) disable iff (!rstN)
    timerEvt |=> !timerEvt);

  a_r12_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LEVEL_FULL);

  a_r10_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    ($past(zeroMode) && txValid) |-> (txData == '0));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underflowErr && !statusClr) |=> underflowErr);
endmodule

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
  import tx_seq_pkg::*;
#(
  parameter int BYTE_CYCLES = 16,
  parameter int LEN_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             engEnable,
  input  logic             cmdValid,
  input  logic [1:0]       cmdCode,
  input  logic             startOnEvt,
  input  logic [2:0]       evtRoute,
  input  logic             timerEvt,
  input  logic [LEN_W-1:0] pktLen,
  input  logic             statusClr,
  output dpCtl_t           ctl,
  output logic             cmdBusy,
  output logic [1:0]       engState,
  output logic [2:0]       endCause,
  output logic             taskDone
);
  localparam int DIV_W = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BYTE_CYCLES - 1);

  state_e           state, stateNxt;
  logic             cmdPend, evtPend;
  logic [1:0]       cmdReg;
  logic [DIV_W-1:0] divCnt;
  logic [LEN_W-1:0] byteCnt;
  logic txCmd, slot, lastByte, finishOk, abort, consume, evtIn;

  always_comb begin
    txCmd    = cmdPend && (cmdReg == CMD_TX);
    evtIn    = timerEvt && (evtRoute != ROUTE_OFF);
    slot     = (state == ST_SEND) && (divCnt == DIV_LAST);
    lastByte = (byteCnt == pktLen - LEN_W'(1));
    finishOk = slot && lastByte && !txCmd;
    abort    = txCmd && (state != ST_IDLE);
    consume  = 1'b0;
    stateNxt = state;
    case (state)
      ST_WAIT: if (evtPend) begin stateNxt = ST_SEND; consume = 1'b1; end
      ST_SEND: if (finishOk) stateNxt = ST_IDLE;
      default: ;
    endcase
    if (txCmd) begin
      stateNxt = startOnEvt ? ST_WAIT : ST_SEND;
      consume  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !engEnable) begin
      state   <= ST_IDLE;
      cmdPend <= 1'b0;
      cmdReg  <= 2'b00;
      evtPend <= 1'b0;
      divCnt  <= '0;
      byteCnt <= '0;
    end else begin
      state   <= stateNxt;
      cmdPend <= cmdValid;
      cmdReg  <= cmdCode;
      if (evtIn) evtPend <= 1'b1;
      else if (consume) evtPend <= 1'b0;
      if (stateNxt == ST_SEND && (state != ST_SEND || txCmd)) begin
        divCnt  <= '0;
        byteCnt <= '0;
      end else if (slot) begin
        divCnt  <= '0;
        byteCnt <= byteCnt + LEN_W'(1);
      end else if (state == ST_SEND) begin
        divCnt  <= divCnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      endCause <= END_NONE;
      taskDone <= 1'b0;
    end else if (engEnable && abort) begin
      endCause <= END_ABORT;
      taskDone <= 1'b1;
    end else if (engEnable && finishOk) begin
      endCause <= END_OK;
      taskDone <= 1'b1;
    end else if (statusClr) begin
      taskDone <= 1'b0;
    end
  end

  always_comb begin
    ctl.fifoFlush = cmdPend && (cmdReg == CMD_FLUSH);
    ctl.byteSlot  = slot && !txCmd && engEnable;
    cmdBusy       = cmdPend;
    if (!engEnable)              engState = ENG_RESET;
    else if (state == ST_SEND)   engState = ENG_SEND;
    else if (state == ST_WAIT)   engState = ENG_WAIT;
    else if (txCmd)              engState = ENG_WAIT;
    else                         engState = ENG_IDLE;
  end

  a_r6_engine_reset: assert property (@(posedge clk) disable iff (!rstN)
    !engEnable |=> (state == ST_IDLE && !evtPend));

  a_r4_hold_until_event: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !evtPend && !cmdPend && engEnable) |=> (state == ST_WAIT));

  a_r5_latch_persists: assert property (@(posedge clk) disable iff (!rstN)
    (evtPend && engEnable && state == ST_IDLE) |=> evtPend);

  a_r7_blocked_not_latched: assert property (@(posedge clk) disable iff (!rstN)
    (!evtPend && (evtRoute == ROUTE_OFF || !timerEvt)) |=> !evtPend);

  a_r8_abort_reported: assert property (@(posedge clk) disable iff (!rstN)
    (txCmd && engEnable && state != ST_IDLE) |=> (endCause == END_ABORT && taskDone));

  a_r9_done_on_last: assert property (@(posedge clk) disable iff (!rstN)
    (finishOk && engEnable) |=> (state == ST_IDLE && endCause == END_OK && taskDone));
endmodule

// File: rtl/tx_task_seq.sv
module tx_task_seq
  import tx_seq_pkg::*;
#(
  parameter int PERIOD_W    = 16,
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int BYTE_CYCLES = 16,
  parameter int LEN_W       = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              engEnable,
  input  logic                              timerRun,
  input  logic [PERIOD_W-1:0]               timerPeriod,
  input  logic [2:0]                        evtRoute,
  input  logic                              startOnEvt,
  input  logic [LEN_W-1:0]                  pktLen,
  input  logic                              cmdValid,
  input  logic [1:0]                        cmdCode,
  output logic                              cmdBusy,
  input  logic                              fifoWrEn,
  input  logic [DATA_W-1:0]                 fifoWrData,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifoLevel,
  input  logic                              statusClr,
  output logic                              txValid,
  output logic [DATA_W-1:0]                 txData,
  output logic [1:0]                        engState,
  output logic [2:0]                        endCause,
  output logic                              taskDone,
  output logic                              underflowErr,
  output logic                              timerEvt
);
  localparam int LEVEL_W = $clog2(FIFO_DEPTH + 1);

  dpCtl_t ctl;

  tx_seq_ctrl #(.BYTE_CYCLES(BYTE_CYCLES), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .engEnable(engEnable),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .startOnEvt(startOnEvt),
    .evtRoute(evtRoute), .timerEvt(timerEvt), .pktLen(pktLen),
    .statusClr(statusClr), .ctl(ctl), .cmdBusy(cmdBusy),
    .engState(engState), .endCause(endCause), .taskDone(taskDone)
  );

  tx_seq_datapath #(.PERIOD_W(PERIOD_W), .DATA_W(DATA_W),
                    .FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .engEnable(engEnable),
    .timerRun(timerRun), .timerPeriod(timerPeriod), .timerEvt(timerEvt),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .fifoLevel(fifoLevel),
    .ctl(ctl), .statusClr(statusClr), .txValid(txValid), .txData(txData),
    .underflowErr(underflowErr)
  );
endmodule

// File: tb/tx_task_seq_tb.sv
module tx_task_seq_tb;
  localparam int FD = 8;
  localparam int BC = 4;
  localparam int PERIOD = 40;

  logic       clk = 1'b0;
  logic       rstN, engEnable, timerRun, startOnEvt, cmdValid, fifoWrEn, statusClr;
  logic [15:0] timerPeriod;
  logic [2:0] evtRoute;
  logic [7:0] pktLen, fifoWrData;
  logic [1:0] cmdCode;
  logic       cmdBusy, txValid, taskDone, underflowErr, timerEvt;
  logic [3:0] fifoLevel;
  logic [7:0] txData;
  logic [1:0] engState;
  logic [2:0] endCause;

  int nChk = 0, nFail = 0, cyc = 0;
  logic [7:0] rx [16];

  localparam int NV = 4;
  localparam int V_LEN  [NV] = '{3, 5, 4, 6};
  localparam int V_NWR  [NV] = '{3, 5, 2, 0};
  localparam int V_SEED [NV] = '{8'h10, 8'hA0, 8'h3C, 8'h55};

  tx_task_seq #(.PERIOD_W(16), .DATA_W(8), .FIFO_DEPTH(FD), .BYTE_CYCLES(BC), .LEN_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .engEnable(engEnable), .timerRun(timerRun),
    .timerPeriod(timerPeriod), .evtRoute(evtRoute), .startOnEvt(startOnEvt),
    .pktLen(pktLen), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBusy(cmdBusy),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .fifoLevel(fifoLevel),
    .statusClr(statusClr), .txValid(txValid), .txData(txData),
    .engState(engState), .endCause(endCause), .taskDone(taskDone),
    .underflowErr(underflowErr), .timerEvt(timerEvt)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run did not end, act=%0d exp<=100000", cyc);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [1:0] code, input string req);
    cmdValid = 1'b1; cmdCode = code;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 2'b00;
    chk({req, " R12 cmdBusy after strobe"}, int'(cmdBusy), 1);
  endtask

  task automatic writeBytes(input int seed, input int n);
    for (int i = 0; i < n; i++) begin
      fifoWrEn = 1'b1; fifoWrData = 8'(seed + i);
      @(negedge clk);
    end
    fifoWrEn = 1'b0;
  endtask

  task automatic flushFifo();
    sendCmd(2'b10, "R10");
    waitN(1);
  endtask

  task automatic clearStatus();
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
  endtask

  task automatic waitEvt();
    int guard = 0;
    while (!timerEvt && guard < 1000) begin @(negedge clk); guard++; end
    if (guard >= 1000) chk("R1 event never seen", 0, 1);
  endtask

  task automatic collect(input int n);
    int got = 0, guard = 0;
    while (got < n && guard < 2000) begin
      @(negedge clk); guard++;
      if (txValid) begin rx[got] = txData; got++; end
    end
    if (got < n) chk("R9 bytes received", got, n);
  endtask

  initial begin
    rstN = 0; engEnable = 1; timerRun = 1; timerPeriod = 16'(PERIOD);
    evtRoute = 3'd0; startOnEvt = 0; pktLen = 8'd4; cmdValid = 0; cmdCode = 0;
    fifoWrEn = 0; fifoWrData = 0; statusClr = 0;
    waitN(3);
    // R13 reset state
    chk("R13 engState", int'(engState), 0);
    chk("R13 endCause", int'(endCause), 0);
    chk("R13 fifoLevel", int'(fifoLevel), 0);
    chk("R13 taskDone", int'(taskDone), 0);
    chk("R13 underflowErr", int'(underflowErr), 0);
    chk("R13 txValid", int'(txValid), 0);
    chk("R13 cmdBusy", int'(cmdBusy), 0);
    rstN = 1;

    // R1 event width and period
    waitEvt();
    @(negedge clk);
    chk("R1 event one clock wide", int'(timerEvt), 0);
    begin
      int n = 1;
      while (!timerEvt && n < 1000) begin @(negedge clk); n++; end
      chk("R1 event spacing", n, PERIOD);
    end

    // R9/R10 table of packets, no event wait
    for (int v = 0; v < NV; v++) begin
      pktLen = 8'(V_LEN[v]);
      flushFifo();
      writeBytes(V_SEED[v], V_NWR[v]);
      chk("R12 fifoLevel after writes", int'(fifoLevel), V_NWR[v]);
      sendCmd(2'b01, "R3");
      @(negedge clk);
      chk("R3 sending without event", int'(engState), 2);
      collect(V_LEN[v]);
      for (int i = 0; i < V_LEN[v]; i++)
        chk((i < V_NWR[v]) ? "R9 byte order" : "R10 zero fill", int'(rx[i]),
            (i < V_NWR[v]) ? ((V_SEED[v] + i) & 8'hFF) : 0);
      chk("R9 taskDone on last byte", int'(taskDone), 1);
      chk("R9 endCause success", int'(endCause), 1);
      chk("R9 engState idle after packet", int'(engState), 0);
      chk("R10 underflow flag", int'(underflowErr), (V_NWR[v] < V_LEN[v]) ? 1 : 0);
      clearStatus();
      chk("R11 taskDone cleared", int'(taskDone), 0);
      chk("R11 underflowErr cleared", int'(underflowErr), 0);
    end

    // R10 zero mode persists over refill until FIFO reset
    flushFifo();
    writeBytes(8'h77, 1);
    pktLen = 8'd5;
    sendCmd(2'b01, "R10");
    collect(2);
    chk("R10 first byte from FIFO", int'(rx[0]), 8'h77);
    chk("R10 underflow byte zero", int'(rx[1]), 0);
    writeBytes(8'hE1, 3);
    collect(3);
    for (int i = 0; i < 3; i++) chk("R10 zero after refill", int'(rx[i]), 0);
    chk("R10 refilled bytes unread", int'(fifoLevel), 3);
    chk("R10 packet completes", int'(endCause), 1);
    flushFifo();
    chk("R12 flush empties FIFO", int'(fifoLevel), 0);
    clearStatus();
    writeBytes(8'h21, 2);
    pktLen = 8'd2;
    sendCmd(2'b01, "R10");
    collect(2);
    chk("R10 data after FIFO reset b0", int'(rx[0]), 8'h21);
    chk("R10 data after FIFO reset b1", int'(rx[1]), 8'h22);
    chk("R10 no underflow after reset", int'(underflowErr), 0);
    clearStatus();

    // R12 overflow dropped
    flushFifo();
    writeBytes(8'h01, 10);
    chk("R12 full FIFO saturates", int'(fifoLevel), FD);
    flushFifo();

    // R8 abort mid-packet
    writeBytes(8'h40, 6);
    pktLen = 8'd6;
    sendCmd(2'b01, "R8");
    collect(1);
    sendCmd(2'b01, "R8");
    @(negedge clk);
    chk("R8 endCause abort", int'(endCause), 6);
    chk("R8 taskDone on abort", int'(taskDone), 1);
    chk("R8 new task sending", int'(engState), 2);
    clearStatus();
    collect(6);
    chk("R8 new task ends ok", int'(endCause), 1);
    clearStatus();
    flushFifo();

    // R4 wait for fresh event
    startOnEvt = 1; pktLen = 8'd2;
    waitEvt();
    engEnable = 0;
    @(negedge clk);
    chk("R6 engState in reset", int'(engState), 3);
    engEnable = 1;
    writeBytes(8'h90, 2);
    sendCmd(2'b01, "R4");
    waitN(5);
    chk("R4 waiting for event", int'(engState), 1);
    waitEvt();
    @(negedge clk);
    chk("R4 still waiting one clock after event", int'(engState), 1);
    @(negedge clk);
    chk("R4 sending after event", int'(engState), 2);
    collect(2);
    chk("R4 data b0", int'(rx[0]), 8'h90);
    chk("R4 task ok", int'(endCause), 1);
    clearStatus();

    // R5 stale event starts next transmit at once
    waitEvt();
    waitN(2);
    chk("R5 idle with pending event", int'(engState), 0);
    writeBytes(8'hA1, 2);
    sendCmd(2'b01, "R5");
    chk("R5 start pending reads not idle", int'(engState), 1);
    @(negedge clk);
    chk("R5 waiting stage", int'(engState), 1);
    @(negedge clk);
    chk("R5 immediate start from latch", int'(engState), 2);
    collect(2);
    clearStatus();

    // R6 engine reset discards pending event
    waitEvt();
    waitN(1);
    engEnable = 0;
    @(negedge clk);
    engEnable = 1;
    writeBytes(8'hB1, 2);
    sendCmd(2'b01, "R6");
    waitN(6);
    chk("R6 stale event cleared, waiting", int'(engState), 1);
    waitEvt();
    waitN(2);
    chk("R6 sending after fresh event", int'(engState), 2);
    collect(2);
    clearStatus();

    // R7 blocked route
    waitN(2);
    evtRoute = 3'd7;
    waitEvt();
    waitN(2);
    evtRoute = 3'd0;
    writeBytes(8'hC1, 2);
    sendCmd(2'b01, "R7");
    waitN(6);
    chk("R7 blocked event not latched", int'(engState), 1);
    waitEvt();
    waitN(2);
    chk("R7 routed event starts task", int'(engState), 2);
    collect(2);
    clearStatus();

    // R2 timer spacing across engine reset
    waitEvt();
    engEnable = 0;
    begin
      int n = 0;
      @(negedge clk); n++;
      while (!timerEvt && n < 1000) begin
        if (n == 5) engEnable = 1;
        @(negedge clk); n++;
      end
      chk("R2 timer spacing across engine reset", n, PERIOD);
    end
    engEnable = 1;

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule